// File: doc/BRIEF.md
# Data Channel Command Engine

This block is one input data channel of a word-oriented computer. A processor first selects a peripheral unit on the channel. The selection is acknowledged only if the unit reports that it is ready. The processor then hands the channel a 36-bit command word. The command word gives an operation code, a word count and a first storage address.

From then on the channel works without the processor. Every word the peripheral offers on a valid/ready stream is written to main memory at the current address. After each word the address advances by one and the count drops by one. When the count reaches zero under the disconnect-type operation code, the channel releases the unit and goes idle. Under any other operation code the channel stays connected and waits for the next command.

Top module: `dch_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `selected`, `sel_ack`, `pw_ready` and `mem_we` are all 0 and `sel_unit` is 0.
- R2: `sel_field[12:9]` names the channel and `sel_field[8:0]` names the unit. A select is accepted when `sel_valid` is high, the channel field equals parameter CHAN_ID (default 1) and `unit_rdy` is high. An accepted select raises `sel_ack` for exactly one cycle, on the edge after it was presented, and sets `selected` with `sel_unit` holding the unit. A select that fails any of these conditions gives no `sel_ack` and leaves the selection unchanged.
- R3: `cmd_word[35:33]` is the operation code, `cmd_word[32:18]` is the word count and `cmd_word[14:0]` is the first storage address; `cmd_word[17:15]` has no effect. A command is taken when `cmd_valid` is high, the channel is selected and `pw_ready` is low. Taking a command replaces all three registers at once, so no earlier count or address survives. `busy` rises on the following edge when the count is nonzero.
- R4: Each word accepted on the peripheral stream (`pw_valid` and `pw_ready` both high at an edge) appears one cycle later on the write port. `mem_we` is 1, `mem_addr` is the address counter as it was before the word and `mem_wdata` is the word.
- R5: `pw_ready` is high exactly when `busy` is high and the word count is nonzero. Each accepted word increments the address by one and decrements the count by one.
- R6: Operation code 000 is the disconnect type. On the edge that accepts the last counted word, `busy` and `selected` both fall. After that, further peripheral words see `pw_ready` low and cause no write.
- R7: The address counter wraps from 32767 to 0.
- R8: A command with a zero word count disconnects on the edge that loads it (`busy` 0, `selected` 0) and causes no memory write.
- R9: For any operation code other than 000, reaching a zero count leaves `busy` and `selected` high with `pw_ready` low. A new command may then be loaded.
- R10: A select is ignored while `busy` is high, even in the cycle that accepts the final word. A command is ignored while no unit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_valid | input | 1 | Select request strobe |
| sel_field | input | 13 | Channel (upper 4 bits) and unit (lower 9 bits) |
| unit_rdy | input | 1 | Addressed unit reports ready |
| sel_ack | output | 1 | One-cycle select acknowledge |
| selected | output | 1 | A unit is connected to the channel |
| sel_unit | output | 9 | Connected unit number |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 36 | Command word |
| busy | output | 1 | Command in progress |
| pw_valid | input | 1 | Peripheral word valid |
| pw_data | input | 36 | Peripheral word |
| pw_ready | output | 1 | Channel accepts a peripheral word |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory write address |
| mem_wdata | output | 36 | Memory write data |

## Verification
The acceptance of the final counted word can fall in the same cycle as a new select request. The disconnect must then win: the write is issued, `busy` and `selected` fall, and the select gets no acknowledge. The bench provokes this by raising `sel_valid` with a ready unit in the very cycle it presents the last word of a wrapping transfer. It then judges `sel_ack`, `busy` and `selected` one edge later, while the scoreboard confirms that exactly the expected write at address 1 came out.

// File: rtl/dch_pkg.sv
package dch_pkg;
  localparam int OP_W = 3;
  typedef logic [OP_W-1:0] op_t;
  localparam op_t OP_DISCONNECT = 3'b000;
endpackage

// File: rtl/dch_select.sv
module dch_select #(
  parameter int CH_W    = 4,
  parameter int UNIT_W  = 9,
  parameter int CHAN_ID = 1,
  localparam int SEL_W  = CH_W + UNIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic [SEL_W-1:0]  sel_field,
  input  logic              unit_rdy,
  input  logic              block,
  input  logic              drop,
  output logic              sel_ack,
  output logic              selected,
  output logic [UNIT_W-1:0] sel_unit
);
  logic [CH_W-1:0]   chan;
  logic [UNIT_W-1:0] unit;
  logic              hit;

  assign chan = sel_field[SEL_W-1 -: CH_W];
  assign unit = sel_field[UNIT_W-1:0];
  assign hit  = sel_valid && (chan == CH_W'(CHAN_ID)) && unit_rdy && !block;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ack  <= 1'b0;
      selected <= 1'b0;
      sel_unit <= '0;
    end else begin
      sel_ack <= hit;
      if (drop) begin
        selected <= 1'b0;
        sel_unit <= '0;
      end else if (hit) begin
        selected <= 1'b1;
        sel_unit <= unit;
      end
    end
  end

  // R2: an acknowledge needs a ready unit and a request on the previous edge
  a_r2_ack_needs_ready: assert property (@(posedge clk) disable iff (rst)
    sel_ack |-> $past(unit_rdy && sel_valid));
  // R10: no acknowledge while the channel is blocked
  a_r10_blocked_no_ack: assert property (@(posedge clk) disable iff (rst)
    block |=> !sel_ack);
endmodule

// File: rtl/dch_cmd_regs.sv
module dch_cmd_regs
  import dch_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              step,
  output op_t               op,
  output logic [CNT_W-1:0]  wc,
  output logic [ADDR_W-1:0] cac,
  output logic              load_zero
);
  localparam int OP_HI  = WORD_W - 1;
  localparam int CNT_HI = WORD_W - 1 - OP_W;
  localparam int GAP_HI = CNT_HI - CNT_W;

  op_t               f_op;
  logic [CNT_W-1:0]  f_cnt;
  logic [ADDR_W-1:0] f_addr;
  logic              unused_gap;

  assign f_op       = cmd_word[OP_HI -: OP_W];
  assign f_cnt      = cmd_word[CNT_HI -: CNT_W];
  assign f_addr     = cmd_word[ADDR_W-1:0];
  assign unused_gap = ^cmd_word[GAP_HI:ADDR_W];
  assign load_zero  = (f_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      op  <= '0;
      wc  <= '0;
      cac <= '0;
    end else if (load) begin
      op  <= f_op;
      wc  <= f_cnt;
      cac <= f_addr;
    end else if (step) begin
      wc  <= wc - CNT_W'(1);
      cac <= cac + ADDR_W'(1);
    end
  end

  // R5: a step never arrives with an exhausted count
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    step |-> wc != '0);
  // R7: address wraps to zero after the top address
  a_r7_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cac == '1) |=> cac == '0);
endmodule

// File: rtl/dch_wport.sv
module dch_wport #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= fire;
      if (fire) begin
        mem_addr  <= addr;
        mem_wdata <= data;
      end
    end
  end
endmodule

// File: rtl/dch_engine.sv
module dch_engine
  import dch_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int CNT_W   = 15,
  parameter int ADDR_W  = 15,
  parameter int CH_W    = 4,
  parameter int UNIT_W  = 9,
  parameter int CHAN_ID = 1,
  localparam int SEL_W  = CH_W + UNIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic [SEL_W-1:0]  sel_field,
  input  logic              unit_rdy,
  output logic              sel_ack,
  output logic              selected,
  output logic [UNIT_W-1:0] sel_unit,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              busy,
  input  logic              pw_valid,
  input  logic [WORD_W-1:0] pw_data,
  output logic              pw_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  op_t               op;
  logic [CNT_W-1:0]  wc;
  logic [ADDR_W-1:0] cac;
  logic load, load_zero, fire, last, disc_end, zero_load, drop, block;
  logic busy_q;

  assign busy      = busy_q;
  assign pw_ready  = busy_q && (wc != '0);
  assign load      = cmd_valid && selected && !pw_ready;
  assign fire      = pw_valid && pw_ready;
  assign last      = fire && (wc == CNT_W'(1));
  assign disc_end  = last && (op == OP_DISCONNECT);
  assign zero_load = load && load_zero;
  assign drop      = zero_load || disc_end;
  assign block     = busy_q || load;

  dch_select #(.CH_W(CH_W), .UNIT_W(UNIT_W), .CHAN_ID(CHAN_ID)) u_sel (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_field(sel_field),
    .unit_rdy(unit_rdy), .block(block), .drop(drop),
    .sel_ack(sel_ack), .selected(selected), .sel_unit(sel_unit));

  dch_cmd_regs #(.WORD_W(WORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .load(load), .cmd_word(cmd_word), .step(fire),
    .op(op), .wc(wc), .cac(cac), .load_zero(load_zero));

  dch_wport #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_wp (
    .clk(clk), .rst(rst), .fire(fire), .addr(cac), .data(pw_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (load)     busy_q <= !load_zero;
    else if (disc_end) busy_q <= 1'b0;
  end

  // R4: every write follows an accepted peripheral word
  a_r4_write_follows: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(pw_valid && pw_ready));
  // R6: the last word under the disconnect code releases the channel
  a_r6_disconnect: assert property (@(posedge clk) disable iff (rst)
    disc_end |=> (!busy_q && !selected && !pw_ready));
  // R6: offered words that are not accepted leave no write behind
  a_r6_ignored_word: assert property (@(posedge clk) disable iff (rst)
    (pw_valid && !pw_ready) |=> !mem_we);
  // R8: a zero count disconnects at load and writes nothing
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    zero_load |=> (!busy_q && !selected && !mem_we));
  // R9: other codes keep the unit connected at zero count
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (last && op != OP_DISCONNECT) |=> (busy_q && selected && !pw_ready));
endmodule

// File: tb/dch_engine_tb_top.sv
module dch_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic sel_valid = 0, unit_rdy = 0, cmd_valid = 0, pw_valid = 0;
  logic [12:0] sel_field = '0;
  logic [35:0] cmd_word = '0, pw_data = '0;
  logic sel_ack, selected, busy, pw_ready, mem_we;
  logic [8:0]  sel_unit;
  logic [14:0] mem_addr;
  logic [35:0] mem_wdata;

  dch_engine dut_i (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_field(sel_field),
    .unit_rdy(unit_rdy), .sel_ack(sel_ack), .selected(selected),
    .sel_unit(sel_unit), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .pw_valid(pw_valid), .pw_data(pw_data), .pw_ready(pw_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int n_run = 0, n_fail = 0;
  logic [14:0] m_addr;
  typedef struct packed { logic [14:0] a; logic [35:0] d; } wr_t;
  wr_t exp_q[$];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected write: actual %0h@%0h expected none", mem_wdata, mem_addr);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d) begin
          n_fail++;
          $display("FAIL R4/R7 write: actual %0h@%0h expected %0h@%0h",
                   mem_wdata, mem_addr, e.d, e.a);
        end
      end
    end
  end

  function automatic logic [35:0] mk_cmd(logic [2:0] op, logic [14:0] cnt,
                                         logic [2:0] gap, logic [14:0] adr);
    return {op, cnt, gap, adr};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_sel(logic [12:0] f, logic rdy, logic exp_ack, string req);
    sel_valid = 1; sel_field = f; unit_rdy = rdy;
    tick();
    chk(req, "sel_ack", sel_ack, exp_ack);
    sel_valid = 0; unit_rdy = 0;
  endtask

  task automatic do_cmd(logic [35:0] w);
    cmd_valid = 1; cmd_word = w;
    tick();
    cmd_valid = 0;
  endtask

  task automatic send(logic [35:0] d, logic acc, string req);
    chk(req, "pw_ready", pw_ready, acc);
    pw_valid = 1; pw_data = d;
    if (acc) begin
      exp_q.push_back('{a: m_addr, d: d});
      m_addr = m_addr + 15'd1;
    end
    tick();
    pw_valid = 0;
  endtask

  localparam logic [12:0] GOOD = {4'd1, 9'd5};

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "selected", selected, 0);
    chk("R1", "pw_ready", pw_ready, 0);
    chk("R1", "sel_unit", sel_unit, 0);

    // R10: command with no unit selected is ignored
    do_cmd(mk_cmd(3'b000, 15'd4, 3'b0, 15'h200));
    chk("R10", "busy after unselected cmd", busy, 0);

    // R2 select decoding
    do_sel({4'd2, 9'd5}, 1, 0, "R2 wrong channel");
    do_sel(GOOD, 0, 0, "R2 unit not ready");
    chk("R2", "selected", selected, 0);
    do_sel(GOOD, 1, 1, "R2 good select");
    chk("R2", "selected", selected, 1);
    chk("R2", "sel_unit", sel_unit, 5);
    tick();
    chk("R2", "ack one cycle", sel_ack, 0);

    // R3/R4/R5/R6 disconnect transfer of two words, gap bits set
    do_cmd(mk_cmd(3'b000, 15'd2, 3'b111, 15'h0014));
    m_addr = 15'h0014;
    chk("R3", "busy", busy, 1);
    chk("R5", "pw_ready", pw_ready, 1);
    do_sel(GOOD, 1, 0, "R10 select while busy");
    send(36'h1_2345_6789, 1, "R4");
    tick();
    send(36'hF_0000_000A, 1, "R5");
    chk("R6", "busy after last", busy, 0);
    chk("R6", "selected after last", selected, 0);
    send(36'h9_9999_9999, 0, "R6 ignored word");
    tick();

    // R7 wrap, last word collides with a select request
    do_sel(GOOD, 1, 1, "R7 select");
    do_cmd(mk_cmd(3'b000, 15'd3, 3'b0, 15'h7FFF));
    m_addr = 15'h7FFF;
    send(36'hA, 1, "R7");
    send(36'hB, 1, "R7");
    chk("R7", "pw_ready", pw_ready, 1);
    pw_valid = 1; pw_data = 36'hC; sel_valid = 1; sel_field = GOOD; unit_rdy = 1;
    exp_q.push_back('{a: m_addr, d: 36'hC});
    tick();
    pw_valid = 0; sel_valid = 0; unit_rdy = 0;
    chk("R10", "sel_ack on final word", sel_ack, 0);
    chk("R6", "busy on collision", busy, 0);
    chk("R6", "selected on collision", selected, 0);
    tick();

    // R8 zero count
    do_sel(GOOD, 1, 1, "R8 select");
    do_cmd(mk_cmd(3'b000, 15'd0, 3'b0, 15'h0300));
    chk("R8", "busy", busy, 0);
    chk("R8", "selected", selected, 0);
    send(36'h5, 0, "R8 no transfer");
    tick();

    // R9 non-disconnect code, then reload
    do_sel(GOOD, 1, 1, "R9 select");
    do_cmd(mk_cmd(3'b010, 15'd1, 3'b0, 15'h0040));
    m_addr = 15'h0040;
    send(36'h77, 1, "R9");
    chk("R9", "busy held", busy, 1);
    chk("R9", "selected held", selected, 1);
    chk("R9", "pw_ready", pw_ready, 0);
    do_cmd(mk_cmd(3'b000, 15'd1, 3'b0, 15'h0100));
    m_addr = 15'h0100;
    send(36'h88, 1, "R3 reload");
    chk("R6", "busy after reload", busy, 0);
    tick(); tick();

    chk("R4", "pending writes", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule